// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a multiplying PLL from one output rate to another without glitching the clock it feeds. A request carries a target rate and the rate of the reference. The block first works out the feedback multiplier by a bit-serial division. It then programs the PLL through a plain register bus: status at base+0x0, control at base+0x4, multiplier word at base+0x8, pre/post divider at base+0xC. It ends with a single-cycle done pulse, with an error flag that tells failure from success.

The multiplier is the smallest integer m with 2·m·target ≥ reference, which is ⌈reference / (2·target)⌉. The multiplier word written to the PLL is not built here. The binary m appears on `mselOut`, and an outside converter returns the encoded word on `mdivIn` within the same cycle. Delays are counted in pulses of an external microsecond strobe, so the block's own clock rate does not matter. The PLL is seen only through its status register. Lock is bit 0 of that register.

Control bit positions: bit 0 power-down, bit 1 bypass, bit 2 direct-input, bit 3 direct-output, bit 4 output enable. A read returns its data on `busRdata` in the cycle after `busRd` is high.

Top module: `pll_retune_seq`

## Requirements
- R1: A request whose target rate is zero, or whose reference is lower than the target, produces done with error in the next cycle and no bus access at all.
- R2: The multiplier word written at base+0x8 is the converter's output for m = ⌈reference / (2·target)⌉.
- R3: The first bus access of an accepted request reads control (base+0x4). The first write is to control and carries the read value with bit 0 set, bits 1 to 4 cleared and every other bit unchanged.
- R4: After the power-down write, the writes follow in a fixed order: the multiplier word at base+0x8, then 0x00302062 at base+0xC, then control with bit 0 cleared and all other bits as in the power-down write.
- R5: Before every status read, at least DELAY_US microsecond strobes have arrived since the previous bus access.
- R6: If a status read returns bit 0 set, the next access writes control with bit 4 set and all other bits kept, and done follows without error.
- R7: After MAX_POLLS status reads without lock, done follows with error, there is no further write, and output enable stays cleared.
- R8: busy rises only on an accepted request and stays high until done. A request raised while busy is ignored.
- R9: done is a one-cycle pulse per request, and err is high only together with done.
- R10: During and right after reset, busy, done, err, busWr and busRd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqRate | input | RATE_W | Requested output rate |
| refRate | input | RATE_W | Reference rate |
| usTick | input | 1 | One-cycle pulse per microsecond |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result pulse |
| err | output | 1 | Failure flag, valid with done |
| mselOut | output | RATE_W | Binary multiplier to the encoder |
| mdivIn | input | 32 | Encoded multiplier word from the encoder |
| busWr | output | 1 | Register write strobe |
| busRd | output | 1 | Register read strobe |
| busAddr | output | ADDR_W | Register address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, one cycle after busRd |

## Verification
Random target and reference pairs across the full 32-bit range test the rounded-up division against an independent 64-bit model. A reference that is an exact multiple of twice the target separates the exact case from the rounding case, and reference equal to target pins the result at one. Each run starts from a different initial control word, including all-ones and all-zeros, so a mask error in the read-modify-write shows up. The number of failed polls before lock is varied across runs (first poll, last poll, never) to separate the enable path from the error path. Reject inputs and a request raised while busy show that no bus traffic and no second sequence occur.

// File: rtl/plr_pkg.sv
package plr_pkg;
  localparam int DATA_W = 32;
  localparam int OFFS_STAT = 0;
  localparam int OFFS_CTRL = 4;
  localparam int OFFS_MULT = 8;
  localparam int OFFS_PREPOST = 12;
  localparam int BIT_PDOWN = 0;
  localparam int BIT_OUTEN = 4;
  localparam int BIT_LOCK = 0;
  localparam logic [DATA_W-1:0] PDOWN_CLEAR_MASK = 32'h0000_001E;
  localparam logic [DATA_W-1:0] PREPOST_UNITY = 32'h0030_2062;

  typedef enum logic [2:0] {WR_NONE, WR_PDOWN, WR_MULT, WR_PREPOST, WR_PUP, WR_OUTEN} wrKind_e;
  typedef enum logic [1:0] {RD_NONE, RD_CTRL, RD_STAT} rdKind_e;

  typedef struct packed {
    logic    loadReq;
    logic    divStep;
    logic    capCtrl;
    logic    capStat;
    logic    clrWait;
    logic    clrPolls;
    wrKind_e wrKind;
    rdKind_e rdKind;
  } seqStrobes_t;

  typedef struct packed {
    logic reqBad;
    logic divDone;
    logic waitDone;
    logic lockSeen;
    logic pollsSpent;
  } seqStatus_t;
endpackage

// File: rtl/plr_datapath.sv
module plr_datapath
  import plr_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h040,
  parameter int DELAY_US = 10,
  parameter int MAX_POLLS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  output seqStatus_t         stat,
  input  logic [RATE_W-1:0]  reqRate,
  input  logic [RATE_W-1:0]  refRate,
  input  logic               usTick,
  output logic [RATE_W-1:0]  mselOut,
  input  logic [DATA_W-1:0]  mdivIn,
  output logic               busWr,
  output logic               busRd,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWdata,
  input  logic [DATA_W-1:0]  busRdata
);
  localparam int CNT_W  = $clog2(RATE_W + 1);
  localparam int WAIT_W = $clog2(DELAY_US + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0]  CNT_START = CNT_W'(RATE_W);
  localparam logic [WAIT_W-1:0] WAIT_END  = WAIT_W'(DELAY_US);
  localparam logic [POLL_W-1:0] POLL_END  = POLL_W'(MAX_POLLS);
  localparam logic [ADDR_W-1:0] ADDR_STAT = BASE_ADDR + ADDR_W'(OFFS_STAT);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = BASE_ADDR + ADDR_W'(OFFS_CTRL);
  localparam logic [ADDR_W-1:0] ADDR_MULT = BASE_ADDR + ADDR_W'(OFFS_MULT);
  localparam logic [ADDR_W-1:0] ADDR_PREPOST = BASE_ADDR + ADDR_W'(OFFS_PREPOST);
  localparam logic [DATA_W-1:0] PDOWN_SET = DATA_W'(1) << BIT_PDOWN;
  localparam logic [DATA_W-1:0] OUTEN_SET = DATA_W'(1) << BIT_OUTEN;

  // bit-serial restoring divider: reference / (2 * target)
  logic [RATE_W-1:0] quo;
  logic [RATE_W:0]   rem;
  logic [RATE_W:0]   dvs;
  logic [CNT_W-1:0]  divCnt;
  logic [RATE_W+1:0] shifted;
  logic              geq;

  assign shifted = {rem, quo[RATE_W-1]};
  assign geq     = shifted >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quo    <= '0;
      rem    <= '0;
      dvs    <= '0;
      divCnt <= '0;
    end else if (strb.loadReq) begin
      quo    <= refRate;
      rem    <= '0;
      dvs    <= {reqRate, 1'b0};
      divCnt <= CNT_START;
    end else if (strb.divStep) begin
      rem    <= geq ? (shifted[RATE_W:0] - dvs) : shifted[RATE_W:0];
      quo    <= {quo[RATE_W-2:0], geq};
      divCnt <= divCnt - 1'b1;
    end
  end

  assign mselOut = quo + RATE_W'(rem != '0);

  // control register shadow and control words
  logic [DATA_W-1:0] ctrlShadow;
  logic [DATA_W-1:0] pdWord, puWord, enWord;
  assign pdWord = (ctrlShadow | PDOWN_SET) & ~PDOWN_CLEAR_MASK;
  assign puWord = ctrlShadow & ~PDOWN_SET;
  assign enWord = ctrlShadow | OUTEN_SET;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlShadow <= '0;
    end else begin
      unique case (1'b1)
        strb.capCtrl:                ctrlShadow <= busRdata;
        (strb.wrKind == WR_PDOWN):   ctrlShadow <= pdWord;
        (strb.wrKind == WR_PUP):     ctrlShadow <= puWord;
        (strb.wrKind == WR_OUTEN):   ctrlShadow <= enWord;
        default:                     ctrlShadow <= ctrlShadow;
      endcase
    end
  end

  // microsecond delay and poll counters
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  logic              lockFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt  <= '0;
      pollCnt  <= '0;
      lockFlag <= 1'b0;
    end else begin
      if (strb.clrWait)                        waitCnt <= '0;
      else if (usTick && waitCnt != WAIT_END)  waitCnt <= waitCnt + 1'b1;
      if (strb.clrPolls)                       pollCnt <= '0;
      else if (strb.rdKind == RD_STAT)         pollCnt <= pollCnt + 1'b1;
      if (strb.loadReq)                        lockFlag <= 1'b0;
      else if (strb.capStat)                   lockFlag <= busRdata[BIT_LOCK];
    end
  end

  assign stat.reqBad     = (reqRate == '0) || (refRate < reqRate);
  assign stat.divDone    = (divCnt == '0);
  assign stat.waitDone   = (waitCnt == WAIT_END);
  assign stat.lockSeen   = busRdata[BIT_LOCK];
  assign stat.pollsSpent = (pollCnt >= POLL_END);

  // register bus
  always_comb begin
    busWr    = (strb.wrKind != WR_NONE);
    busRd    = (strb.rdKind != RD_NONE);
    busAddr  = ADDR_STAT;
    busWdata = '0;
    unique case (strb.wrKind)
      WR_PDOWN:   begin busAddr = ADDR_CTRL;    busWdata = pdWord;        end
      WR_MULT:    begin busAddr = ADDR_MULT;    busWdata = mdivIn;        end
      WR_PREPOST: begin busAddr = ADDR_PREPOST; busWdata = PREPOST_UNITY; end
      WR_PUP:     begin busAddr = ADDR_CTRL;    busWdata = puWord;        end
      WR_OUTEN:   begin busAddr = ADDR_CTRL;    busWdata = enWord;        end
      default: begin
        if (strb.rdKind == RD_CTRL) busAddr = ADDR_CTRL;
      end
    endcase
  end

  assert_pdown_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrKind == WR_PDOWN) |=> (ctrlShadow[BIT_PDOWN] && ((ctrlShadow & PDOWN_CLEAR_MASK) == '0)));
  assert_wait_elapsed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdKind == RD_STAT) |-> (waitCnt == WAIT_END));
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_END);
  assert_enable_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrKind == WR_OUTEN) |-> lockFlag);
endmodule

// File: rtl/plr_control.sv
module plr_control
  import plr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  seqStatus_t  stat,
  output seqStrobes_t strb,
  output logic        busy,
  output logic        done,
  output logic        err
);
  typedef enum logic [3:0] {
    S_IDLE, S_DIV, S_RDCTRL, S_RDCTRLW, S_WRPD, S_WRMULT, S_WRNP,
    S_WRPU, S_WAIT, S_RDSTAT, S_RDSTATW, S_WREN, S_OK, S_FAIL
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb        = '0;
    strb.wrKind = WR_NONE;
    strb.rdKind = RD_NONE;
    nextState   = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.loadReq = 1'b1;
        nextState    = stat.reqBad ? S_FAIL : S_DIV;
      end
      S_DIV: begin
        if (stat.divDone) nextState = S_RDCTRL;
        else              strb.divStep = 1'b1;
      end
      S_RDCTRL:  begin strb.rdKind = RD_CTRL;    nextState = S_RDCTRLW; end
      S_RDCTRLW: begin strb.capCtrl = 1'b1;      nextState = S_WRPD;    end
      S_WRPD:    begin strb.wrKind = WR_PDOWN;   nextState = S_WRMULT;  end
      S_WRMULT:  begin strb.wrKind = WR_MULT;    nextState = S_WRNP;    end
      S_WRNP: begin
        strb.wrKind   = WR_PREPOST;
        strb.clrPolls = 1'b1;
        nextState     = S_WRPU;
      end
      S_WRPU: begin
        strb.wrKind  = WR_PUP;
        strb.clrWait = 1'b1;
        nextState    = S_WAIT;
      end
      S_WAIT:   if (stat.waitDone) nextState = S_RDSTAT;
      S_RDSTAT: begin strb.rdKind = RD_STAT; nextState = S_RDSTATW; end
      S_RDSTATW: begin
        strb.capStat = 1'b1;
        if (stat.lockSeen)        nextState = S_WREN;
        else if (stat.pollsSpent) nextState = S_FAIL;
        else begin
          strb.clrWait = 1'b1;
          nextState    = S_WAIT;
        end
      end
      S_WREN:  begin strb.wrKind = WR_OUTEN; nextState = S_OK; end
      S_OK:    nextState = S_IDLE;
      S_FAIL:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_OK) || (state == S_FAIL);
  assign err  = (state == S_FAIL);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import plr_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h040,
  parameter int DELAY_US = 10,
  parameter int MAX_POLLS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [RATE_W-1:0] refRate,
  input  logic              usTick,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [RATE_W-1:0] mselOut,
  input  logic [31:0]       mdivIn,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata
);
  seqStrobes_t strb;
  seqStatus_t  stat;

  plr_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat),
    .strb(strb), .busy(busy), .done(done), .err(err)
  );

  plr_datapath #(
    .RATE_W(RATE_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .DELAY_US(DELAY_US), .MAX_POLLS(MAX_POLLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .reqRate(reqRate), .refRate(refRate), .usTick(usTick),
    .mselOut(mselOut), .mdivIn(mdivIn),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/sim_pll_retune_seq.sv
`timescale 1ns/1ps
module sim_pll_retune_seq;
  localparam int DELAY = 10;
  localparam int POLLS = 4;
  localparam logic [11:0] A_STAT = 12'h040;
  localparam logic [11:0] A_CTRL = 12'h044;
  localparam logic [11:0] A_MULT = 12'h048;
  localparam logic [11:0] A_NP   = 12'h04C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqRate = '0, refRate = '0;
  logic usTick = 1'b0;
  logic busy, done, err, busWr, busRd;
  logic [31:0] mselOut, mdivIn, busWdata;
  logic [31:0] rdQ = '0;
  logic [11:0] busAddr;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] conv(logic [31:0] m);
    return (m * 32'd40503) ^ 32'h5A5A_0001;
  endfunction
  assign mdivIn = conv(mselOut);

  pll_retune_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRate(reqRate), .refRate(refRate),
    .usTick(usTick), .busy(busy), .done(done), .err(err), .mselOut(mselOut),
    .mdivIn(mdivIn), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdQ)
  );

  int checks = 0, failures = 0;
  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // microsecond strobe
  int tickDiv = 3;
  int tickPhase = 0;
  initial forever begin
    @(posedge clk); #1;
    tickPhase++;
    usTick = (tickPhase % tickDiv == 0);
  end

  // register model of the PLL
  logic [31:0] mCtrl = '0, mMult = '0, mNp = '0;
  int statReads = 0, lockAfter = 0;
  always @(posedge clk) begin
    if (busWr) begin
      if (busAddr == A_CTRL) mCtrl <= busWdata;
      if (busAddr == A_MULT) mMult <= busWdata;
      if (busAddr == A_NP)   mNp   <= busWdata;
    end
    if (busRd) begin
      if (busAddr == A_STAT) begin
        rdQ <= {31'b0, statReads >= lockAfter};
        statReads <= statReads + 1;
      end else if (busAddr == A_CTRL) rdQ <= mCtrl;
      else rdQ <= 32'hBAD0_BAD0;
    end
  end

  // bus and result monitor
  logic        opWr[64];
  logic [11:0] opAddr[64];
  logic [31:0] opData[64];
  int opCnt = 0, doneCnt = 0, tickRun = 0, strayErr = 0;
  logic lastErr = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busWr || busRd) begin
        if (opCnt < 64) begin
          opWr[opCnt]   = busWr;
          opAddr[opCnt] = busAddr;
          opData[opCnt] = busWr ? busWdata : tickRun;
        end
        opCnt++;
        tickRun = 0;
      end else if (usTick) tickRun++;
      if (done) begin doneCnt++; lastErr = err; end
      if (err && !done) strayErr++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_req(logic [31:0] rf, logic [31:0] rt, logic [31:0] initCtrl,
                         int lockA, bit interject, bit expectBusy);
    @(negedge clk);
    opCnt = 0; doneCnt = 0; strayErr = 0;
    mCtrl = initCtrl; statReads = 0; lockAfter = lockA;
    refRate = rf; reqRate = rt; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (expectBusy) chk(busy === 1'b1, "R8 busy after accept", busy, 1);
    if (interject) begin
      repeat (5) @(negedge clk);
      chk(busy === 1'b1, "R8 busy before interject", busy, 1);
      refRate = 32'd1000; reqRate = 32'd1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    for (int w = 0; w < 5000 && doneCnt == 0; w++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_run(logic [31:0] rf, logic [31:0] rt, logic [31:0] initCtrl, int lockA);
    longint unsigned m;
    logic [31:0] pd, pu, en;
    int reads, expN;
    bit ok;
    m  = (longint'(rf) + 2 * longint'(rt) - 1) / (2 * longint'(rt));
    pd = (initCtrl | 32'h1) & ~32'h1E;
    pu = pd & ~32'h1;
    en = pu | 32'h10;
    ok = lockA < POLLS;
    reads = ok ? lockA + 1 : POLLS;
    expN = 5 + reads + (ok ? 1 : 0);
    chk(opCnt == expN, "R4 access count", opCnt, expN);
    if (opCnt >= expN) begin
      chk(!opWr[0] && opAddr[0] == A_CTRL, "R3 first access reads control", opAddr[0], A_CTRL);
      chk(opWr[1] && opAddr[1] == A_CTRL && opData[1] == pd, "R3 power-down write", opData[1], pd);
      chk(opWr[2] && opAddr[2] == A_MULT && opData[2] == conv(m[31:0]), "R2 multiplier word",
          opData[2], conv(m[31:0]));
      chk(opWr[3] && opAddr[3] == A_NP && opData[3] == 32'h0030_2062, "R4 unity divider word",
          opData[3], 32'h0030_2062);
      chk(opWr[4] && opAddr[4] == A_CTRL && opData[4] == pu, "R4 power-up write", opData[4], pu);
      for (int i = 0; i < reads; i++) begin
        chk(!opWr[5+i] && opAddr[5+i] == A_STAT, "R5 status read address", opAddr[5+i], A_STAT);
        chk(opData[5+i] >= DELAY, "R5 ticks before status read", opData[5+i], DELAY);
      end
      if (ok) chk(opWr[5+reads] && opAddr[5+reads] == A_CTRL && opData[5+reads] == en,
                  "R6 enable write", opData[5+reads], en);
    end
    chk(doneCnt == 1, "R9 one done pulse", doneCnt, 1);
    chk(strayErr == 0, "R9 err only with done", strayErr, 0);
    if (ok) chk(lastErr == 1'b0, "R6 success result", lastErr, 0);
    else begin
      chk(lastErr == 1'b1, "R7 error after exhausted polls", lastErr, 1);
      chk(mCtrl[4] == 1'b0, "R7 output enable stays off", mCtrl[4], 0);
    end
  endtask

  task automatic reject_run(logic [31:0] rf, logic [31:0] rt);
    run_req(rf, rt, 32'h0000_0013, 0, 1'b0, 1'b0);
    chk(opCnt == 0, "R1 no bus access on reject", opCnt, 0);
    chk(doneCnt == 1 && lastErr == 1'b1, "R1 error result on reject", lastErr, 1);
  endtask

  initial begin
    logic [31:0] rf, rt, ic;
    int la;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10 outputs in reset", {busy, done, err}, 0);
    chk(busWr === 1'b0 && busRd === 1'b0, "R10 bus idle in reset", {busWr, busRd}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && busWr === 1'b0 && busRd === 1'b0, "R10 idle after reset",
        {busy, busWr, busRd}, 0);

    run_req(32'd12000000, 32'd6000000, 32'h0000_001F, 0, 1'b0, 1'b1);
    expect_run(32'd12000000, 32'd6000000, 32'h0000_001F, 0);
    run_req(32'd1000, 32'd1000, 32'hFFFF_FFFF, 3, 1'b0, 1'b1);
    expect_run(32'd1000, 32'd1000, 32'hFFFF_FFFF, 3);
    run_req(32'd100000000, 32'd333, 32'hA5A5_0012, 7, 1'b0, 1'b1);
    expect_run(32'd100000000, 32'd333, 32'hA5A5_0012, 7);
    reject_run(32'd5, 32'd6);
    reject_run(32'd100, 32'd0);
    run_req(32'd48000000, 32'd1000000, 32'h0000_0000, 1, 1'b1, 1'b1);
    expect_run(32'd48000000, 32'd1000000, 32'h0000_0000, 1);
    run_req(32'hFFFF_FFFF, 32'd1, 32'h1234_5678, 2, 1'b0, 1'b1);
    expect_run(32'hFFFF_FFFF, 32'd1, 32'h1234_5678, 2);

    for (int n = 0; n < 24; n++) begin
      rt = (n % 3 == 0) ? $urandom_range(1, 5000) : $urandom;
      if (rt == 0) rt = 1;
      rf = $urandom;
      if (rf < rt) begin rf = rt; rt = $urandom_range(1, 64); if (rf < rt) rf = rt; end
      ic = $urandom;
      la = $urandom_range(0, 5);
      tickDiv = $urandom_range(1, 4);
      run_req(rf, rt, ic, la, 1'b0, 1'b1);
      expect_run(rf, rt, ic, la);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule